// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the software-visible register bank of a serial port that has a receive FIFO. It holds the configuration registers: frame mode, bit-rate divisor, control, FIFO control and port-pin control. It also holds a status register whose event flags software clears one at a time. The transmitter, bit-rate generator and receive FIFO storage live outside the block. Bytes written for transmission leave as a one-cycle valid pulse. Break and receive events enter as single-cycle strobes. The receive FIFO head and fill level are read through the bank.

Software reaches the bank over a simple synchronous bus. A write is one cycle with `bus_wr` high. A read is one cycle with `bus_rd` high, and `bus_rdata` is valid combinationally in that cycle. Side effects of a read take hold at the closing clock edge. Two interrupt requests go to the interrupt controller: a transmit request that follows a control bit, and a receive request that is raised by a receive-full event and dropped by software.

Top module: `sio_regbank`

## Requirements
- R1: After reset, status reads 0x0060 (tx-end and tx-empty set), bit rate reads 0x00FF, control reads 0x0020, every other register reads 0, and both interrupt requests are low.
- R2: Register offsets are mode 0x00, bit rate 0x04, control 0x08, transmit data 0x0C (reads 0), status 0x10, receive data 0x14, FIFO control 0x18, receive level 0x1C, port 0x20 and line status 0x24. Writes keep only the bits 0x7B of mode, 0xFA of control and 0xF3 of port. Bit rate takes all 8 bits and FIFO control takes the full bus width.
- R3: Status bits are tx-end at bit 6, tx-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0, and all other bits read 0. A status write clears each of these flags whose written bit is 0 and leaves a flag unchanged where the written bit is 1.
- R4: A write to transmit data produces `tx_valid` high for exactly one cycle, in the cycle after the write, with `tx_byte` equal to the written low byte. It also clears tx-empty.
- R5: A control write with bit 5 at 0 sets tx-end. A status read while control bit 5 is 1 returns the flags as they were, and then sets tx-empty and tx-end.
- R6: `tx_irq` equals control bit 7 at all times.
- R7: `rx_irq` rises in the cycle after a receive-full strobe seen while control bit 6 is 1. It falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0.
- R8: `brk_evt` sets break, `rx_full_evt` sets receive-full and `rx_data_evt` sets data-ready. When a strobe and a clearing write hit the same flag or request in one cycle, the strobe wins.
- R9: Line status (0x24) and every unmapped offset read 0, and writes to them change no register.
- R10: A read of 0x14 returns `rx_head` and pulses `rx_pop` in that cycle. A read of 0x1C returns `rx_level`, zero-extended.
- R11: `rx_trig` is 1, 4, 8 or 14 for FIFO-control bits 7:6 equal to 0, 1, 2 or 3. A FIFO-control write with bit 1 set pulses `fifo_clr` for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| tx_valid | output | 1 | One-cycle pulse carrying a byte to the transmitter |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| brk_evt | input | 1 | Break detected strobe |
| rx_full_evt | input | 1 | Receive FIFO reached its trigger level |
| rx_data_evt | input | 1 | Receive data ready strobe |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_pop | output | 1 | Remove the head byte from the receive FIFO |
| rx_trig | output | LVL_W | Receive trigger level picked by FIFO control |
| fifo_clr | output | 1 | One-cycle request to empty the receive FIFO |

## Verification
The bench aims at cycles where an event strobe and a zero-write to status land together. A design that lets the clear win there loses a break or receive-full flag. It also reads status while transmit is enabled, checking that the returned value predates the re-arm: a design that re-arms first reports tx-empty even after a transmit-data write. Writes of all-ones to every offset, including the unmapped ones, expose a wrong mask or a decoder that aliases into a real register. The bench also drives receive-full strobes with control bit 6 both set and clear, which catches a receive request raised when it is disabled or dropped by the wrong status bit.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

    // register offsets (byte addresses)
    localparam int OFS_MODE   = 'h00;
    localparam int OFS_RATE   = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_TXD    = 'h0C;
    localparam int OFS_STAT   = 'h10;
    localparam int OFS_RXD    = 'h14;
    localparam int OFS_FCTL   = 'h18;
    localparam int OFS_RXLVL  = 'h1C;
    localparam int OFS_PORT   = 'h20;
    localparam int OFS_LINE   = 'h24;

    // writable-bit masks
    localparam logic [7:0] MASK_MODE = 8'h7B;
    localparam logic [7:0] MASK_CTRL = 8'hFA;
    localparam logic [7:0] MASK_PORT = 8'hF3;

    // reset values
    localparam logic [7:0] RST_RATE = 8'hFF;
    localparam logic [7:0] RST_CTRL = 8'h20;

    // control bit positions
    localparam int CTRL_TXIE = 7;
    localparam int CTRL_RXIE = 6;
    localparam int CTRL_TXEN = 5;

    // status bit positions
    localparam int ST_TEND = 6;
    localparam int ST_TDE  = 5;
    localparam int ST_BRK  = 4;
    localparam int ST_RDF  = 1;
    localparam int ST_DR   = 0;

    // FIFO control bit positions
    localparam int FC_CLR = 1;
    localparam int FC_TRG = 6;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flag_t;

    typedef struct packed {
        logic mode;
        logic rate;
        logic ctrl;
        logic txd;
        logic stat;
        logic rxd;
        logic fctl;
        logic rxlvl;
        logic port;
        logic line;
    } hit_t;

    function automatic logic [3:0] trig_of(input logic [1:0] sel);
        case (sel)
            2'd0:    trig_of = 4'd1;
            2'd1:    trig_of = 4'd4;
            2'd2:    trig_of = 4'd8;
            default: trig_of = 4'd14;
        endcase
    endfunction

    function automatic logic [7:0] stat_byte(input flag_t f);
        stat_byte = '0;
        stat_byte[ST_TEND] = f.tend;
        stat_byte[ST_TDE]  = f.tde;
        stat_byte[ST_BRK]  = f.brk;
        stat_byte[ST_RDF]  = f.rdf;
        stat_byte[ST_DR]   = f.dr;
    endfunction

endpackage

// File: rtl/sio_cfg.sv
`timescale 1ns/1ps
module sio_cfg
    import sio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_rate,
    input  logic              wr_ctrl,
    input  logic              wr_fctl,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        mode_q,
    output logic [7:0]        rate_q,
    output logic [7:0]        ctrl_q,
    output logic [DATA_W-1:0] fctl_q,
    output logic [7:0]        port_q,
    output logic              fifo_clr
);

    typedef struct packed {
        logic [7:0]        mode;
        logic [7:0]        rate;
        logic [7:0]        ctrl;
        logic [DATA_W-1:0] fctl;
        logic [7:0]        port;
        logic              clr;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (wr_mode) st_d.mode = wdata[7:0] & MASK_MODE;
        if (wr_rate) st_d.rate = wdata[7:0];
        if (wr_ctrl) st_d.ctrl = wdata[7:0] & MASK_CTRL;
        if (wr_port) st_d.port = wdata[7:0] & MASK_PORT;
        if (wr_fctl) begin
            st_d.fctl = wdata;
            st_d.clr  = wdata[FC_CLR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rate <= RST_RATE;
            st_q.ctrl <= RST_CTRL;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q   = st_q.mode;
    assign rate_q   = st_q.rate;
    assign ctrl_q   = st_q.ctrl;
    assign fctl_q   = st_q.fctl;
    assign port_q   = st_q.port;
    assign fifo_clr = st_q.clr;

    // R2
    mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & ~MASK_MODE) == 8'h00);

    // R11
    fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fctl && wdata[FC_CLR]) |=> fifo_clr);

endmodule

// File: rtl/sio_flags.sv
`timescale 1ns/1ps
module sio_flags
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_txd,
    input  logic       wr_stat,
    input  logic       rd_stat,
    input  logic [7:0] wbyte,
    input  logic [7:0] ctrl_q,
    input  logic       brk_evt,
    input  logic       rx_full_evt,
    input  logic       rx_data_evt,
    output flag_t      flags_q,
    output logic       rx_irq
);

    typedef struct packed {
        flag_t f;
        logic  irq;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software-driven changes
        if (wr_ctrl) begin
            if (!wbyte[CTRL_TXEN]) st_d.f.tend = 1'b1;
            if (!wbyte[CTRL_RXIE]) st_d.irq    = 1'b0;
        end
        if (wr_txd) st_d.f.tde = 1'b0;
        if (wr_stat) begin
            if (!wbyte[ST_TEND]) st_d.f.tend = 1'b0;
            if (!wbyte[ST_TDE])  st_d.f.tde  = 1'b0;
            if (!wbyte[ST_BRK])  st_d.f.brk  = 1'b0;
            if (!wbyte[ST_RDF])  st_d.f.rdf  = 1'b0;
            if (!wbyte[ST_DR])   st_d.f.dr   = 1'b0;
            if (!wbyte[ST_RDF] || !wbyte[ST_DR]) st_d.irq = 1'b0;
        end
        // re-arm after the read value has been taken
        if (rd_stat && ctrl_q[CTRL_TXEN]) begin
            st_d.f.tde  = 1'b1;
            st_d.f.tend = 1'b1;
        end
        // hardware events win over clears
        if (brk_evt)     st_d.f.brk = 1'b1;
        if (rx_data_evt) st_d.f.dr  = 1'b1;
        if (rx_full_evt) begin
            st_d.f.rdf = 1'b1;
            if (ctrl_q[CTRL_RXIE]) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.f.tend <= 1'b1;
            st_q.f.tde  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.f;
    assign rx_irq  = st_q.irq;

    // R4
    tde_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && !rd_stat) |=> !flags_q.tde);

    // R5
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && ctrl_q[CTRL_TXEN]) |=> (flags_q.tde && flags_q.tend));

    // R8
    brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> flags_q.brk);

    // R3
    brk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wbyte[ST_BRK] && !brk_evt) |=> $stable(flags_q.brk));

    // R7
    rxirq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wbyte[CTRL_RXIE] && !rx_full_evt) |=> !rx_irq);

    // R7
    rxirq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(rx_full_evt));

endmodule

// File: rtl/sio_regbank.sv
`timescale 1ns/1ps
module sio_regbank
    import sio_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              brk_evt,
    input  logic              rx_full_evt,
    input  logic              rx_data_evt,
    input  logic [7:0]        rx_head,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              rx_pop,
    output logic [LVL_W-1:0]  rx_trig,
    output logic              fifo_clr
);

    hit_t              hit;
    logic [7:0]        mode_q, rate_q, ctrl_q, port_q;
    logic [DATA_W-1:0] fctl_q;
    flag_t             flags_q;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } txo_t;

    txo_t tx_d, tx_q;

    // address decode
    always_comb begin
        hit       = '0;
        hit.mode  = (bus_addr == ADDR_W'(OFS_MODE));
        hit.rate  = (bus_addr == ADDR_W'(OFS_RATE));
        hit.ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        hit.txd   = (bus_addr == ADDR_W'(OFS_TXD));
        hit.stat  = (bus_addr == ADDR_W'(OFS_STAT));
        hit.rxd   = (bus_addr == ADDR_W'(OFS_RXD));
        hit.fctl  = (bus_addr == ADDR_W'(OFS_FCTL));
        hit.rxlvl = (bus_addr == ADDR_W'(OFS_RXLVL));
        hit.port  = (bus_addr == ADDR_W'(OFS_PORT));
        hit.line  = (bus_addr == ADDR_W'(OFS_LINE));
    end

    sio_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (bus_wr && hit.mode),
        .wr_rate  (bus_wr && hit.rate),
        .wr_ctrl  (bus_wr && hit.ctrl),
        .wr_fctl  (bus_wr && hit.fctl),
        .wr_port  (bus_wr && hit.port),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .rate_q   (rate_q),
        .ctrl_q   (ctrl_q),
        .fctl_q   (fctl_q),
        .port_q   (port_q),
        .fifo_clr (fifo_clr)
    );

    sio_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (bus_wr && hit.ctrl),
        .wr_txd      (bus_wr && hit.txd),
        .wr_stat     (bus_wr && hit.stat),
        .rd_stat     (bus_rd && hit.stat),
        .wbyte       (bus_wdata[7:0]),
        .ctrl_q      (ctrl_q),
        .brk_evt     (brk_evt),
        .rx_full_evt (rx_full_evt),
        .rx_data_evt (rx_data_evt),
        .flags_q     (flags_q),
        .rx_irq      (rx_irq)
    );

    // transmit byte hand-off
    always_comb begin
        tx_d.valid = bus_wr && hit.txd;
        tx_d.data  = tx_q.data;
        if (bus_wr && hit.txd) tx_d.data = bus_wdata[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_valid = tx_q.valid;
    assign tx_byte  = tx_q.data;
    assign tx_irq   = ctrl_q[CTRL_TXIE];
    assign rx_pop   = bus_rd && hit.rxd;
    assign rx_trig  = LVL_W'(trig_of(fctl_q[FC_TRG +: 2]));

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (1'b1)
                hit.mode:  bus_rdata = DATA_W'(mode_q);
                hit.rate:  bus_rdata = DATA_W'(rate_q);
                hit.ctrl:  bus_rdata = DATA_W'(ctrl_q);
                hit.stat:  bus_rdata = DATA_W'(stat_byte(flags_q));
                hit.rxd:   bus_rdata = DATA_W'(rx_head);
                hit.fctl:  bus_rdata = fctl_q;
                hit.rxlvl: bus_rdata = DATA_W'(rx_level);
                hit.port:  bus_rdata = DATA_W'(port_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R4
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit.txd) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));

    // R4
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit.txd) |=> !tx_valid);

    // R9
    line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit.line) |-> (bus_rdata == '0));

    // R10
    pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_rd && $onehot0(hit)));

endmodule

// File: tb/tb_sio_regbank.sv
`timescale 1ns/1ps
module tb_sio_regbank;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int LVL_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tx_valid, tx_irq, rx_irq, rx_pop, fifo_clr;
    logic [7:0]        tx_byte;
    logic              brk_evt = 1'b0, rx_full_evt = 1'b0, rx_data_evt = 1'b0;
    logic [7:0]        rx_head = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic [LVL_W-1:0]  rx_trig;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    sio_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .brk_evt(brk_evt), .rx_full_evt(rx_full_evt), .rx_data_evt(rx_data_evt),
        .rx_head(rx_head), .rx_level(rx_level), .rx_pop(rx_pop),
        .rx_trig(rx_trig), .fifo_clr(fifo_clr)
    );

    // reference model state
    logic [7:0]  m_mode, m_rate, m_ctrl, m_port;
    logic [15:0] m_fctl;
    logic        m_tend, m_tde, m_brk, m_rdf, m_dr, m_irq, m_txv, m_clr;
    logic [7:0]  m_txb;

    task automatic model_reset();
        m_mode = 0; m_rate = 8'hFF; m_ctrl = 8'h20; m_port = 0; m_fctl = 0;
        m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_irq = 0;
        m_txv = 0; m_clr = 0; m_txb = 0;
    endtask

    function automatic logic [3:0] exp_trig(input logic [1:0] s);
        case (s)
            2'd0: return 4'd1;
            2'd1: return 4'd4;
            2'd2: return 4'd8;
            default: return 4'd14;
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return {8'h0, m_mode};
            6'h04: return {8'h0, m_rate};
            6'h08: return {8'h0, m_ctrl};
            6'h10: return {9'h0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
            6'h14: return {8'h0, rx_head};
            6'h18: return m_fctl;
            6'h1C: return {11'h0, rx_level};
            6'h20: return {8'h0, m_port};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // model update for one clock edge, using the pre-edge state
    task automatic model_step(input bit wr, input bit rd, input logic [5:0] a,
                              input logic [15:0] wd, input bit be, input bit fe,
                              input bit de);
        logic [7:0] c0;
        c0 = m_ctrl;
        m_txv = wr && a == 6'h0C;
        if (m_txv) m_txb = wd[7:0];
        m_clr = wr && a == 6'h18 && wd[1];
        if (wr) begin
            case (a)
                6'h00: m_mode = wd[7:0] & 8'h7B;
                6'h04: m_rate = wd[7:0];
                6'h08: begin
                    m_ctrl = wd[7:0] & 8'hFA;
                    if (!wd[5]) m_tend = 1;
                    if (!wd[6]) m_irq = 0;
                end
                6'h0C: m_tde = 0;
                6'h10: begin
                    if (!wd[6]) m_tend = 0;
                    if (!wd[5]) m_tde = 0;
                    if (!wd[4]) m_brk = 0;
                    if (!wd[1]) m_rdf = 0;
                    if (!wd[0]) m_dr = 0;
                    if (!wd[1] || !wd[0]) m_irq = 0;
                end
                6'h18: m_fctl = wd;
                6'h20: m_port = wd[7:0] & 8'hF3;
                default: ;
            endcase
        end
        if (rd && a == 6'h10 && c0[5]) begin m_tde = 1; m_tend = 1; end
        if (be) m_brk = 1;
        if (de) m_dr = 1;
        if (fe) begin m_rdf = 1; if (c0[6]) m_irq = 1; end
    endtask

    task automatic step(input bit wr, input bit rd, input logic [5:0] a,
                        input logic [15:0] wd, input bit be, input bit fe,
                        input bit de, input string req);
        logic [15:0] e;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        brk_evt = be; rx_full_evt = fe; rx_data_evt = de;
        rx_head = 8'($urandom); rx_level = LVL_W'($urandom_range(0, 16));
        #1;
        if (rd) begin
            e = exp_read(a);
            chk(bus_rdata == e, req, bus_rdata, e);
        end
        // R10 pop pulses only on a receive-data read
        chk(rx_pop == (rd && a == 6'h14), "R10", 16'(rx_pop), 16'(rd && a == 6'h14));
        @(posedge clk);
        model_step(wr, rd, a, wd, be, fe, de);
        #1;
        chk(tx_valid == m_txv, "R4", 16'(tx_valid), 16'(m_txv));
        if (m_txv) chk(tx_byte == m_txb, "R4", 16'(tx_byte), 16'(m_txb));
        chk(tx_irq == m_ctrl[7], "R6", 16'(tx_irq), 16'(m_ctrl[7]));
        chk(rx_irq == m_irq, "R7", 16'(rx_irq), 16'(m_irq));
        chk(fifo_clr == m_clr, "R11", 16'(fifo_clr), 16'(m_clr));
        chk(rx_trig == LVL_W'(exp_trig(m_fctl[7:6])), "R11", 16'(rx_trig),
            16'(exp_trig(m_fctl[7:6])));
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [15:0] d, input string req);
        step(1, 0, a, d, 0, 0, 0, req);
    endtask

    task automatic rd_reg(input logic [5:0] a, input string req);
        step(0, 1, a, 16'h0, 0, 0, 0, req);
    endtask

    initial begin
        void'($urandom(32'h5107));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        for (int i = 0; i < 16; i++) rd_reg(6'(i * 4), "R1");

        // R2 masks: all ones everywhere, then read back (R9: unmapped ignored)
        for (int i = 0; i < 16; i++)
            if (i != 3 && i != 4) wr_reg(6'(i * 4), 16'hFFFF, "R2");
        for (int i = 0; i < 16; i++) rd_reg(6'(i * 4), "R2");
        wr_reg(6'h3F, 16'h0000, "R9");
        wr_reg(6'h24, 16'h0000, "R9");
        for (int i = 0; i < 10; i++) rd_reg(6'(i * 4), "R9");

        // R11 trigger levels
        for (int s = 0; s < 4; s++) wr_reg(6'h18, 16'(s << 6), "R11");

        // R4/R5 transmit write then status read order
        wr_reg(6'h08, 16'h0020, "R5");
        wr_reg(6'h0C, 16'h00A5, "R4");
        rd_reg(6'h10, "R5");
        rd_reg(6'h10, "R5");
        wr_reg(6'h10, 16'h0000, "R3");
        wr_reg(6'h08, 16'h0000, "R5");
        rd_reg(6'h10, "R5");

        // R8 set wins over clear
        step(1, 0, 6'h10, 16'h0000, 1, 1, 1, "R8");
        rd_reg(6'h10, "R8");
        // R7 receive request
        wr_reg(6'h08, 16'h0040, "R7");
        step(0, 0, 6'h00, 16'h0, 0, 1, 0, "R7");
        wr_reg(6'h10, 16'h00FD, "R7");
        step(0, 0, 6'h00, 16'h0, 0, 1, 0, "R7");
        wr_reg(6'h10, 16'h00FF, "R3");
        step(1, 0, 6'h08, 16'h0000, 0, 1, 0, "R7");
        wr_reg(6'h08, 16'h0000, "R7");
        step(0, 0, 6'h00, 16'h0, 0, 1, 0, "R7");
        rd_reg(6'h14, "R10");
        rd_reg(6'h1C, "R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] a;
            int op;
            a = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'($urandom_range(0, 11) * 4);
            op = $urandom_range(0, 2);
            step(op == 0, op == 1, a, 16'($urandom),
                 $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 7) == 0, "R3");
        end

        @(negedge clk);
        bus_wr = 0; bus_rd = 0; brk_evt = 0; rx_full_evt = 0; rx_data_evt = 0;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule